// File: doc/BRIEF.md
# Region-Based Bus Wait-State Generator

This block sits beside a processor bus and decides how long each access must wait before the slave side may signal completion. When an access is accepted, the block reads its region code, its direction and a few qualifiers. It works out the wait count from fixed rules or from programmed wait values. It then counts that many cycles down and raises a one-cycle ready strobe. Some regions can be stretched further by a peripheral or an external ready line, and others cannot. The block also adds cycles for a second bus master requesting the same region, and for back-to-back writes to one pipelined peripheral sub-region.

The programmed values come from configuration registers outside the block. They are sampled and clamped at the moment an access is accepted. One access is handled at a time. A request that arrives while an access is still waiting is dropped. The master holds off until it sees ready, and then issues its next request.

Top module: `bus_wait_gen`

## Requirements
- R1: Region codes 0 (tightly coupled RAM) and 1 (fast peripheral frame) complete reads and writes with zero waits, so ready is high in the cycle right after the accepting edge.
- R2: Region codes 2 (stretchable peripheral frame) and 3 (fixed peripheral frame) complete writes with zero waits and reads with 2 waits.
- R3: A read in region 2 that has used up its 2 waits is held for as long as `i_periph_rdy` is low. A read in region 3 ignores `i_periph_rdy` and always takes exactly 2 waits.
- R4: A write to region 2 with `i_sub_hit` high costs 1 extra wait when the access accepted just before it was also a region-2 write with `i_sub_hit` high. Any other access in between clears this penalty.
- R5: Region code 4 (external bus) waits `max(i_ext_wait, 1)` cycles. After that count the access is held while `i_ext_rdy` is low.
- R6: A write to region 4 with `i_wbuf_en` high and `i_wbuf_full` low is posted. It takes zero waits and ignores `i_ext_rdy`. With the buffer full or disabled, the write follows R5.
- R7: When `i_m2_req` is high and `i_m2_region` equals `i_region` at the accepting edge, 1 extra wait is added. A different region adds nothing.
- R8: Region code 5 (flash) waits `max(i_flash_page_wait, 1)` when `i_paged` is high. Otherwise it waits the larger of `max(i_flash_rand_wait, 1)` and the clamped paged count.
- R9: Region code 6 (protected password area) always waits 16 cycles, whatever the programmed values are.
- R10: Region code 7 (boot ROM) always waits exactly 1 cycle.
- R11: Ready is high for exactly one cycle per access. Requests seen while an access is in progress, including during its ready cycle, are dropped. Ready stays low after reset until a request arrives.
- R12: Programmed wait values are sampled and clamped only at the accepting edge. Changing them during an access leaves that access's wait count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_req | input | 1 | Access request, accepted when idle |
| i_write | input | 1 | 1 = write, 0 = read |
| i_region | input | 3 | Region code of the access |
| i_paged | input | 1 | Flash access is a paged (sequential) access |
| i_sub_hit | input | 1 | Access targets the pipelined peripheral sub-region |
| i_ext_wait | input | PROG_W | Programmed external-bus wait count |
| i_flash_page_wait | input | PROG_W | Programmed flash paged wait count |
| i_flash_rand_wait | input | PROG_W | Programmed flash random wait count |
| i_wbuf_en | input | 1 | External-bus write buffer enabled |
| i_wbuf_full | input | 1 | External-bus write buffer full |
| i_periph_rdy | input | 1 | Peripheral ready for the stretchable frame |
| i_ext_rdy | input | 1 | External bus ready |
| i_m2_req | input | 1 | Second master requests in this cycle |
| i_m2_region | input | 3 | Region code of the second master's request |
| o_ready | output | 1 | One-cycle completion strobe |

## Verification
The assertions take for granted that the ready inputs and the programmed values are already synchronous to `clk`. They also assume a request is seen only at the edge where the block is idle. The zero-wait and one-wait properties apply only when no second-master request targets the same region in that cycle. The directed stimulus keeps within these bounds. It drives every input at the falling edge, issues each request as a one-cycle pulse after the previous ready strobe, and raises the second-master request only in the tests aimed at arbitration.

// File: rtl/wsg_pkg.sv
// Package: shared region codes and sizing helpers for the wait-state generator.
// Assumes region codes are 3 bits wide; neighbouring decode logic relies on these values.
package wsg_pkg;

    typedef enum logic [2:0] {
        RG_TCM        = 3'd0,
        RG_PF_FAST    = 3'd1,
        RG_PF_STRETCH = 3'd2,
        RG_PF_FIXED   = 3'd3,
        RG_EXT        = 3'd4,
        RG_FLASH      = 3'd5,
        RG_PWD        = 3'd6,
        RG_BOOT       = 3'd7
    } region_e;

    // Per-access hold behaviour captured at acceptance.
    typedef struct packed {
        logic on_periph;   // stretch by peripheral ready once count expires
        logic on_ext;      // stretch by external ready once count expires
    } hold_t;

endpackage

// File: rtl/wsg_rule.sv
// Module: wsg_rule
// Turns the region code, direction and programmed values of an access into its
// base wait count and its hold behaviour. Purely combinational; the values are
// meant to be captured only at the accepting edge.
// Assumes CNT_W is wide enough for the largest programmed value and for PWD_WAITS.
module wsg_rule
    import wsg_pkg::*;
#(
    parameter int PROG_W        = 4,
    parameter int CNT_W         = 6,
    parameter int PWD_WAITS     = 16,
    parameter int SLOW_RD_WAITS = 2,
    parameter int BOOT_WAITS    = 1,
    parameter int PROG_MIN      = 1
) (
    input  logic [2:0]        region,
    input  logic              write,
    input  logic              paged,
    input  logic [PROG_W-1:0] ext_wait,
    input  logic [PROG_W-1:0] page_wait,
    input  logic [PROG_W-1:0] rand_wait,
    input  logic              wbuf_en,
    input  logic              wbuf_full,
    output logic [CNT_W-1:0]  base_cnt,
    output hold_t             hold
);

    localparam logic [CNT_W-1:0] C_SLOW = CNT_W'(SLOW_RD_WAITS);
    localparam logic [CNT_W-1:0] C_PWD  = CNT_W'(PWD_WAITS);
    localparam logic [CNT_W-1:0] C_BOOT = CNT_W'(BOOT_WAITS);
    localparam logic [CNT_W-1:0] C_MIN  = CNT_W'(PROG_MIN);

    region_e              rg;
    logic                 posted;
    logic [CNT_W-1:0]     ext_c;
    logic [CNT_W-1:0]     page_c;
    logic [CNT_W-1:0]     rand_c;
    logic [CNT_W-1:0]     flash_c;

    // Raises a programmed value to the region minimum.
    function automatic logic [CNT_W-1:0] clamp_min(input logic [PROG_W-1:0] v);
        logic [CNT_W-1:0] w;
        w = {{(CNT_W-PROG_W){1'b0}}, v};
        return (w < C_MIN) ? C_MIN : w;
    endfunction

    assign rg = region_e'(region);

    // Clamp programmed counts and enforce random >= paged for flash.
    always_comb begin
        ext_c   = clamp_min(ext_wait);
        page_c  = clamp_min(page_wait);
        rand_c  = clamp_min(rand_wait);
        if (rand_c < page_c) begin
            rand_c = page_c;
        end
        flash_c = paged ? page_c : rand_c;
    end

    // A posted external write needs a buffer slot.
    assign posted = (rg == RG_EXT) && write && wbuf_en && !wbuf_full;

    // Select the base count per region class.
    always_comb begin
        base_cnt = '0;
        unique case (rg)
            RG_TCM, RG_PF_FAST:        base_cnt = '0;
            RG_PF_STRETCH, RG_PF_FIXED: base_cnt = write ? '0 : C_SLOW;
            RG_EXT:                    base_cnt = posted ? '0 : ext_c;
            RG_FLASH:                  base_cnt = flash_c;
            RG_PWD:                    base_cnt = C_PWD;
            RG_BOOT:                   base_cnt = C_BOOT;
            default:                   base_cnt = '0;
        endcase
    end

    // Decide which ready line may stretch this access.
    always_comb begin
        hold.on_periph = (rg == RG_PF_STRETCH) && !write;
        hold.on_ext    = (rg == RG_EXT) && !posted;
    end

endmodule

// File: rtl/wsg_penalty.sv
// Module: wsg_penalty
// Works out the extra waits from two sources. One is arbitration against a second
// master that requests the same region in the same cycle. The other is the pipeline
// hit on back-to-back writes to the designated sub-region of the stretchable frame.
// Assumes 'accept' is high for exactly the edge at which an access is taken.
module wsg_penalty
    import wsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic [2:0] region,
    input  logic       write,
    input  logic       sub_hit,
    input  logic       m2_req,
    input  logic [2:0] m2_region,
    output logic [1:0] extra
);

    logic last_sub_wr;
    logic this_sub_wr;
    logic sub_pen;
    logic arb_pen;

    assign this_sub_wr = (region_e'(region) == RG_PF_STRETCH) && write && sub_hit;
    assign sub_pen     = this_sub_wr && last_sub_wr;
    assign arb_pen     = m2_req && (m2_region == region);
    assign extra       = {1'b0, sub_pen} + {1'b0, arb_pen};

    // Remember whether the last accepted access was a sub-region write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_sub_wr <= 1'b0;
        end else if (accept) begin
            last_sub_wr <= this_sub_wr;
        end
    end

endmodule

// File: rtl/wsg_timer.sv
// Module: wsg_timer
// Holds the loaded wait count, counts it down and then applies the captured hold
// rule against the ready lines. Ready is high for exactly one cycle, after which
// the timer returns to idle.
// Assumes 'accept' is only raised while 'busy' is low.
module wsg_timer
    import wsg_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [CNT_W-1:0] load_cnt,
    input  hold_t            load_hold,
    input  logic             periph_rdy,
    input  logic             ext_rdy,
    output logic             busy,
    output logic             cnt_zero,
    output hold_t            hold_q,
    output logic             ready
);

    logic [CNT_W-1:0] cnt_q;
    logic             stall;

    assign cnt_zero = (cnt_q == '0);
    assign stall    = (hold_q.on_periph && !periph_rdy) || (hold_q.on_ext && !ext_rdy);
    assign ready    = busy && cnt_zero && !stall;

    // Load on accept, count down, then release once the hold clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt_q  <= '0;
            hold_q <= '0;
        end else if (accept) begin
            busy   <= 1'b1;
            cnt_q  <= load_cnt;
            hold_q <= load_hold;
        end else if (busy) begin
            if (!cnt_zero) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (!stall) begin
                busy <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bus_wait_gen.sv
// Module: bus_wait_gen (top)
// Region-based wait-state generator. It accepts one access at a time, works out
// its wait count from the region rules and the penalties, and raises a one-cycle
// ready when the count and any hold have expired.
// Assumes all inputs are synchronous to clk; requests made while busy are dropped.
module bus_wait_gen
    import wsg_pkg::*;
#(
    parameter int PROG_W        = 4,
    parameter int PWD_WAITS     = 16,
    parameter int SLOW_RD_WAITS = 2,
    parameter int BOOT_WAITS    = 1,
    parameter int PROG_MIN      = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_req,
    input  logic              i_write,
    input  logic [2:0]        i_region,
    input  logic              i_paged,
    input  logic              i_sub_hit,
    input  logic [PROG_W-1:0] i_ext_wait,
    input  logic [PROG_W-1:0] i_flash_page_wait,
    input  logic [PROG_W-1:0] i_flash_rand_wait,
    input  logic              i_wbuf_en,
    input  logic              i_wbuf_full,
    input  logic              i_periph_rdy,
    input  logic              i_ext_rdy,
    input  logic              i_m2_req,
    input  logic [2:0]        i_m2_region,
    output logic              o_ready
);

    localparam int PWD_BITS = $clog2(PWD_WAITS + 1);
    localparam int CNT_W    = ((PROG_W > PWD_BITS) ? PROG_W : PWD_BITS) + 1;

    logic             accept;
    logic             busy;
    logic             cnt_zero;
    logic [CNT_W-1:0] base_cnt;
    logic [CNT_W-1:0] total_cnt;
    logic [1:0]       extra;
    hold_t            hold_new;
    hold_t            hold_q;

    assign accept    = i_req && !busy;
    assign total_cnt = base_cnt + CNT_W'(extra);

    wsg_rule #(
        .PROG_W       (PROG_W),
        .CNT_W        (CNT_W),
        .PWD_WAITS    (PWD_WAITS),
        .SLOW_RD_WAITS(SLOW_RD_WAITS),
        .BOOT_WAITS   (BOOT_WAITS),
        .PROG_MIN     (PROG_MIN)
    ) u_rule (
        .region   (i_region),
        .write    (i_write),
        .paged    (i_paged),
        .ext_wait (i_ext_wait),
        .page_wait(i_flash_page_wait),
        .rand_wait(i_flash_rand_wait),
        .wbuf_en  (i_wbuf_en),
        .wbuf_full(i_wbuf_full),
        .base_cnt (base_cnt),
        .hold     (hold_new)
    );

    wsg_penalty u_pen (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .region   (i_region),
        .write    (i_write),
        .sub_hit  (i_sub_hit),
        .m2_req   (i_m2_req),
        .m2_region(i_m2_region),
        .extra    (extra)
    );

    wsg_timer #(
        .CNT_W(CNT_W)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .load_cnt  (total_cnt),
        .load_hold (hold_new),
        .periph_rdy(i_periph_rdy),
        .ext_rdy   (i_ext_rdy),
        .busy      (busy),
        .cnt_zero  (cnt_zero),
        .hold_q    (hold_q),
        .ready     (o_ready)
    );

endmodule

// File: rtl/wsg_checker.sv
// Module: wsg_checker
// Property checks for bus_wait_gen, attached with bind. Assumes synchronous inputs.
module wsg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       i_req,
    input logic       i_write,
    input logic [2:0] i_region,
    input logic       i_wbuf_en,
    input logic       i_wbuf_full,
    input logic       i_periph_rdy,
    input logic       i_ext_rdy,
    input logic       i_m2_req,
    input logic [2:0] i_m2_region,
    input logic       o_ready,
    input logic       busy,
    input logic       cnt_zero,
    input logic       hold_periph,
    input logic       hold_ext
);

    logic no_arb;
    assign no_arb = !(i_m2_req && (i_m2_region == i_region));

    p_fast_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && i_req && (i_region <= 3'd1) && no_arb) |=> o_ready);

    p_periph_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_zero && hold_periph && !i_periph_rdy) |-> !o_ready);

    p_ext_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_zero && hold_ext && !i_ext_rdy) |-> !o_ready);

    p_posted_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && i_req && i_write && (i_region == 3'd4) && i_wbuf_en && !i_wbuf_full && no_arb)
        |=> o_ready);

    p_boot_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && i_req && (i_region == 3'd7) && no_arb) |=> !o_ready ##1 o_ready);

    p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        o_ready |=> !o_ready);

    p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && i_req) |=> busy);

endmodule

bind bus_wait_gen wsg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .i_req       (i_req),
    .i_write     (i_write),
    .i_region    (i_region),
    .i_wbuf_en   (i_wbuf_en),
    .i_wbuf_full (i_wbuf_full),
    .i_periph_rdy(i_periph_rdy),
    .i_ext_rdy   (i_ext_rdy),
    .i_m2_req    (i_m2_req),
    .i_m2_region (i_m2_region),
    .o_ready     (o_ready),
    .busy        (busy),
    .cnt_zero    (cnt_zero),
    .hold_periph (hold_q.on_periph),
    .hold_ext    (hold_q.on_ext)
);

// File: tb/tb_bus_wait_gen.sv
`timescale 1ns/1ps
module tb_bus_wait_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       i_req = 1'b0;
    logic       i_write = 1'b0;
    logic [2:0] i_region = 3'd0;
    logic       i_paged = 1'b0;
    logic       i_sub_hit = 1'b0;
    logic [3:0] i_ext_wait = 4'd0;
    logic [3:0] i_flash_page_wait = 4'd0;
    logic [3:0] i_flash_rand_wait = 4'd0;
    logic       i_wbuf_en = 1'b0;
    logic       i_wbuf_full = 1'b0;
    logic       i_periph_rdy = 1'b1;
    logic       i_ext_rdy = 1'b1;
    logic       i_m2_req = 1'b0;
    logic [2:0] i_m2_region = 3'd0;
    logic       o_ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    bus_wait_gen dut (
        .clk(clk), .rst_n(rst_n), .i_req(i_req), .i_write(i_write),
        .i_region(i_region), .i_paged(i_paged), .i_sub_hit(i_sub_hit),
        .i_ext_wait(i_ext_wait), .i_flash_page_wait(i_flash_page_wait),
        .i_flash_rand_wait(i_flash_rand_wait), .i_wbuf_en(i_wbuf_en),
        .i_wbuf_full(i_wbuf_full), .i_periph_rdy(i_periph_rdy), .i_ext_rdy(i_ext_rdy),
        .i_m2_req(i_m2_req), .i_m2_region(i_m2_region), .o_ready(o_ready)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Issue one request pulse; returns after the accepting edge.
    task automatic launch(input logic [2:0] rg, input logic wr, input bit hold_low);
        @(negedge clk);
        i_region = rg;
        i_write  = wr;
        if (hold_low) begin
            i_periph_rdy = 1'b0;
            i_ext_rdy    = 1'b0;
        end
        i_req = 1'b1;
        @(posedge clk);
        #1 i_req = 1'b0;
    endtask

    // Count waits until ready; release ready lines at wait index rel (if >= 0).
    task automatic measure(input int rel, output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (rel >= 0 && n == rel) begin
                i_periph_rdy = 1'b1;
                i_ext_rdy    = 1'b1;
            end
            #0.5;
            if (o_ready || n > 300) break;
            n++;
        end
        i_periph_rdy = 1'b1;
        i_ext_rdy    = 1'b1;
        i_m2_req     = 1'b0;
    endtask

    task automatic access(input logic [2:0] rg, input logic wr, input int rel,
                          input int exp, input string tag);
        int n;
        launch(rg, wr, rel >= 0);
        measure(rel, n);
        check(n, exp, tag);
    endtask

    task automatic t_reset();
        int hi = 0;
        repeat (3) begin
            @(negedge clk);
            if (o_ready) hi++;
        end
        check(hi, 0, "R11 ready low after reset");
    endtask

    task automatic t_fast();
        access(3'd0, 1'b0, -1, 0, "R1 tcm read");
        access(3'd0, 1'b1, -1, 0, "R1 tcm write");
        access(3'd1, 1'b0, -1, 0, "R1 fast frame read");
        access(3'd1, 1'b1, -1, 0, "R1 fast frame write");
    endtask

    task automatic t_slow();
        access(3'd2, 1'b1, -1, 0, "R2 stretch frame write");
        access(3'd2, 1'b0, -1, 2, "R2 stretch frame read");
        access(3'd3, 1'b1, -1, 0, "R2 fixed frame write");
        access(3'd3, 1'b0, -1, 2, "R2 fixed frame read");
    endtask

    task automatic t_stretch();
        access(3'd2, 1'b0, 5, 5, "R3 periph ready stretches read");
        access(3'd3, 1'b0, 9, 2, "R3 fixed frame ignores periph ready");
        access(3'd2, 1'b1, 7, 0, "R3 stretch frame write not held");
    endtask

    task automatic t_sub();
        i_sub_hit = 1'b1;
        access(3'd2, 1'b1, -1, 0, "R4 first sub write");
        access(3'd2, 1'b1, -1, 1, "R4 second sub write");
        access(3'd2, 1'b1, -1, 1, "R4 third sub write");
        i_sub_hit = 1'b0;
        access(3'd0, 1'b0, -1, 0, "R4 break access");
        i_sub_hit = 1'b1;
        access(3'd2, 1'b1, -1, 0, "R4 sub write after break");
        i_sub_hit = 1'b0;
        access(3'd2, 1'b1, -1, 0, "R4 non-sub write");
    endtask

    task automatic t_ext();
        i_wbuf_en  = 1'b0;
        i_ext_wait = 4'd0;
        access(3'd4, 1'b0, -1, 1, "R5 ext wait 0 clamped to 1");
        i_ext_wait = 4'd3;
        access(3'd4, 1'b0, -1, 3, "R5 ext wait 3");
        access(3'd4, 1'b0, 6, 6, "R5 ext ready extends");
        i_ext_wait = 4'd2;
        access(3'd4, 1'b1, -1, 2, "R5 ext write buffer off");
    endtask

    task automatic t_posted();
        i_wbuf_en   = 1'b1;
        i_wbuf_full = 1'b0;
        i_ext_wait  = 4'd4;
        access(3'd4, 1'b1, 8, 0, "R6 posted write zero wait");
        i_wbuf_full = 1'b1;
        access(3'd4, 1'b1, -1, 4, "R6 buffer full write");
        i_wbuf_full = 1'b0;
        access(3'd4, 1'b0, -1, 4, "R6 read not posted");
        i_wbuf_en = 1'b0;
    endtask

    task automatic t_arb();
        i_m2_req = 1'b1; i_m2_region = 3'd0;
        access(3'd0, 1'b0, -1, 1, "R7 same region contention");
        i_m2_req = 1'b1; i_m2_region = 3'd5;
        access(3'd0, 1'b0, -1, 0, "R7 other region no penalty");
        i_m2_req = 1'b1; i_m2_region = 3'd7;
        access(3'd7, 1'b0, -1, 2, "R7 boot rom contention");
    endtask

    task automatic t_flash();
        i_flash_page_wait = 4'd3; i_flash_rand_wait = 4'd6; i_paged = 1'b1;
        access(3'd5, 1'b0, -1, 3, "R8 paged 3");
        i_flash_page_wait = 4'd0;
        access(3'd5, 1'b0, -1, 1, "R8 paged 0 clamped");
        i_paged = 1'b0; i_flash_page_wait = 4'd5; i_flash_rand_wait = 4'd2;
        access(3'd5, 1'b0, -1, 5, "R8 random raised to paged");
        i_flash_page_wait = 4'd2; i_flash_rand_wait = 4'd7;
        access(3'd5, 1'b1, -1, 7, "R8 random 7");
        i_flash_page_wait = 4'd0; i_flash_rand_wait = 4'd0;
        access(3'd5, 1'b0, -1, 1, "R8 random 0 clamped");
    endtask

    task automatic t_fixed();
        i_ext_wait = 4'd15; i_flash_page_wait = 4'd15; i_flash_rand_wait = 4'd15;
        access(3'd6, 1'b0, -1, 16, "R9 password read");
        access(3'd6, 1'b1, -1, 16, "R9 password write");
        access(3'd7, 1'b0, -1, 1, "R10 boot read");
    endtask

    // Requests during an access are dropped; ready is a single-cycle strobe.
    task automatic t_busy_ignore();
        int n = 0;
        int extra = 0;
        launch(3'd6, 1'b0, 1'b0);
        forever begin
            @(negedge clk);
            i_req = (n == 3 || n == 4);
            i_region = (n == 3 || n == 4) ? 3'd0 : 3'd6;
            #0.5;
            if (o_ready || n > 300) break;
            n++;
        end
        check(n, 16, "R11 long access undisturbed");
        i_req = 1'b1;
        i_region = 3'd0;
        @(negedge clk);
        i_req = 1'b0;
        #0.5;
        check(int'(o_ready), 0, "R11 ready one cycle, request in ready cycle dropped");
        repeat (4) begin
            @(negedge clk);
            #0.5;
            if (o_ready) extra++;
        end
        check(extra, 0, "R11 no ready from dropped requests");
    endtask

    task automatic t_sample_once();
        int n;
        i_ext_wait = 4'd5;
        launch(3'd4, 1'b0, 1'b0);
        i_ext_wait = 4'd0;
        measure(-1, n);
        check(n, 5, "R12 ext wait sampled at accept");
        i_paged = 1'b1; i_flash_page_wait = 4'd0;
        launch(3'd5, 1'b0, 1'b0);
        i_flash_page_wait = 4'd9;
        measure(-1, n);
        check(n, 1, "R12 flash clamp at accept");
        i_paged = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fast();
        t_slow();
        t_stretch();
        t_sub();
        t_ext();
        t_posted();
        t_arb();
        t_flash();
        t_fixed();
        t_busy_ignore();
        t_sample_once();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule